// File: doc/BRIEF.md
# Auto-Reload Countdown Interval Timer

This block is a periodic interval timer. Software writes a 16-bit start value as two bytes through a small write-only register port. A write to the high byte loads the counter with the full value and starts the countdown. The counter counts down by one on each cycle where the selected tick enable is high. When the count runs out, the block raises a one-cycle expiry pulse for the interrupt router, loads the start value again and keeps counting. The result is a steady stream of events, one every N ticks.

There are two time bases. One is a fast system-rate tick enable. The other is a slow tick enable that fires once per video scan line. A configuration bit picks one of them. The tick sources themselves are made outside the block, and so is the latching of the interrupt. A start value of zero parks the timer, and it then gives no events.

Top module: `reload_timer`

## Requirements
- R1: After reset the stored start value is zero, the fast tick is selected and the timer is stopped. `expire` stays low, even if the high byte is then written with 0x00 and no low-byte write has come first.
- R2: A write to address 0 (the high byte) stores the byte and loads the counter with {written byte, stored low byte}. With a non-zero value N and a tick on every cycle, the first pulse follows the N-th edge after the write edge. All 16 bits count.
- R3: A write to address 1 (the low byte) changes only the stored start value. The running count is neither restarted nor reloaded, and the new value is used from the next automatic reload onward.
- R4: When the last tick of a period is taken, `expire` is high for exactly one cycle, the counter reloads from the stored start value in that same cycle, and counting goes on. Under steady ticks the pulses repeat every N ticks.
- R5: The counter moves only on clock edges where the selected tick-enable input is high. On other edges it holds.
- R6: Bit 0 of a write to address 2 picks the time base: 0 for `tick_fast`, 1 for `tick_line`. The input that is not selected has no effect.
- R7: A start value of zero stops the timer. This holds whether the zero comes from a high-byte write or from an automatic reload. No pulse comes until a later high-byte write gives a non-zero value.
- R8: A high-byte write while the timer is running restarts the period at once from the new full value. The write wins over a tick on the same edge.
- R9: `expire` is a registered output. It is high in the cycle that follows the edge on which the final tick of a period was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 high byte, 1 low byte, 2 configuration |
| wr_data | input | 8 | Write data |
| tick_fast | input | 1 | Fast system-rate tick enable |
| tick_line | input | 1 | Once-per-scan-line tick enable |
| expire | output | 1 | One-cycle expiry event |

## Verification
The only result is the expiry pulse. It rises in the cycle after the clock edge that took the final tick of a period. So when a high-byte write is sampled on edge k and a tick comes every cycle, the pulse follows edge k+N, and then k+2N, and so on. With gated ticks, the pulse follows the edge where the N-th selected tick falls. The bench numbers every clock edge. It works out the edge of each expected pulse from the tick patterns it drives and the writes it makes, and it samples `expire` on the falling edge. A pulse seen there belongs to the edge just before. Any pulse that comes early, late or when none is expected is reported against the requirement under test.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_ADDR_W = 2;

  typedef enum logic [TMR_ADDR_W-1:0] {
    REG_HI  = 2'd0,
    REG_LO  = 2'd1,
    REG_CFG = 2'd2
  } tmr_reg_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [TMR_ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  output logic                  load_stb_o,
  output logic [2*BYTE_W-1:0]   load_val_o,
  output logic [2*BYTE_W-1:0]   reload_val_o,
  output logic                  sel_line_o
);
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              sel_q, sel_d;
  logic              wr_hi, wr_lo, wr_cfg;

  assign wr_hi  = wr_en_i && (wr_addr_i == REG_HI);
  assign wr_lo  = wr_en_i && (wr_addr_i == REG_LO);
  assign wr_cfg = wr_en_i && (wr_addr_i == REG_CFG);

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    sel_d = sel_q;
    if (wr_hi)  hi_d  = wr_data_i;
    if (wr_lo)  lo_d  = wr_data_i;
    if (wr_cfg) sel_d = wr_data_i[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      sel_q <= sel_d;
    end
  end

  assign load_stb_o   = wr_hi;
  assign load_val_o   = {wr_data_i, lo_q};
  assign reload_val_o = {hi_q, lo_q};
  assign sel_line_o   = sel_q;

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_lo |=> $stable(hi_q)); // R3
endmodule

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux (
  input  logic sel_line_i,
  input  logic tick_fast_i,
  input  logic tick_line_i,
  output logic tick_o
);
  always_comb begin
    tick_o = sel_line_i ? tick_line_i : tick_fast_i;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_stb_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             exp_q, exp_d;
  logic             last_tick;

  assign last_tick = run_q && tick_i && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_d = 1'b0;
    if (load_stb_i) begin
      cnt_d = load_val_i;
      run_d = (load_val_i != '0);
    end else if (last_tick) begin
      exp_d = 1'b1;
      cnt_d = reload_val_i;
      run_d = (reload_val_i != '0);
    end else if (run_q && tick_i) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;

  AST_RELOAD_WITH_EXPIRE: assert property (@(posedge clk) disable iff (!rst_ni)
    exp_q |-> (cnt_q == $past(reload_val_i))); // R4
  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    run_q |-> (cnt_q != '0)); // R4
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_q && !tick_i && !load_stb_i) |=> ($stable(cnt_q) && !exp_q)); // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && !load_stb_i) |=> (!exp_q && $stable(cnt_q))); // R7
  AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    load_stb_i |=> !exp_q); // R8
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TMR_ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic                  tick_fast,
  input  logic                  tick_line,
  output logic                  expire
);
  localparam int CNT_W = 2 * BYTE_W;

  logic             rst_int_n;
  logic             load_stb;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] reload_val;
  logic             sel_line;
  logic             tick;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_int_n)
  );

  tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .load_stb_o   (load_stb),
    .load_val_o   (load_val),
    .reload_val_o (reload_val),
    .sel_line_o   (sel_line)
  );

  tmr_tick_mux u_mux (
    .sel_line_i  (sel_line),
    .tick_fast_i (tick_fast),
    .tick_line_i (tick_line),
    .tick_o      (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_ni       (rst_int_n),
    .load_stb_i   (load_stb),
    .load_val_i   (load_val),
    .reload_val_i (reload_val),
    .tick_i       (tick),
    .expire_o     (expire)
  );
endmodule

// File: tb/test_reload_timer.sv
module test_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       tick_fast;
  logic       tick_line;
  logic       expire;

  typedef struct {
    int    ek;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    cyc = 0;
  int    nchk = 0;
  int    nfail = 0;
  bit    mon_on = 0;
  bit    fast_mode = 0;
  bit    sel_b = 0;
  string phase = "R1";
  localparam int NEVER = 1 << 30;

  reload_timer i_reload_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick_fast (tick_fast),
    .tick_line (tick_line),
    .expire    (expire)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit fast_at(int k);
    return fast_mode ? (k % 3 == 0) : 1'b1;
  endfunction

  function automatic bit line_at(int k);
    return (k % 16 == 5);
  endfunction

  function automatic bit tick_at(int k);
    return sel_b ? line_at(k) : fast_at(k);
  endfunction

  // ticks for edge number cyc are set up half a cycle ahead
  always @(negedge clk) begin
    tick_fast = fast_at(cyc);
    tick_line = line_at(cyc);
  end

  // monitor: a pulse seen now belongs to edge cyc-1
  always @(negedge clk) begin
    if (mon_on) begin
      while (expq.size() > 0 && expq[0].ek < cyc - 1) begin
        nchk++; nfail++;
        $display("FAIL %s: pulse missing, actual none, expected after edge %0d",
                 expq[0].tag, expq[0].ek);
        void'(expq.pop_front());
      end
      if (expire) begin
        nchk++;
        if (expq.size() > 0 && expq[0].ek == cyc - 1) begin
          void'(expq.pop_front());
        end else begin
          nfail++;
          $display("FAIL %s: unexpected pulse, actual after edge %0d, expected %0d",
                   phase, cyc - 1, (expq.size() > 0) ? expq[0].ek : -1);
        end
      end
    end
  end

  task automatic wr_at(int k, logic [1:0] a, logic [7:0] d);
    while (cyc != k) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver side of the scoreboard: expected pulse edges in (k0, kend)
  task automatic predict(int k0, int kend, int n0, int kw, int n1, string tag);
    int rem = n0;
    for (int k = k0 + 1; k < kend; k++) begin
      if (rem != 0 && tick_at(k)) begin
        rem--;
        if (rem == 0) begin
          expq.push_back('{k, tag});
          rem = (k > kw) ? n1 : n0;
        end
      end
    end
  endtask

  task automatic stop_at(int kend);
    wr_at(kend - 1, 2'd1, 8'h00);
    wr_at(kend, 2'd0, 8'h00);
  endtask

  task automatic idle_check(int n, string tag);
    int seen = 0;
    phase = tag;
    repeat (n) begin
      @(negedge clk);
      if (expire) seen++;
    end
    nchk++;
    if (seen != 0) begin
      nfail++;
      $display("FAIL %s: pulses while idle, actual %0d, expected 0", tag, seen);
    end
  endtask

  initial begin
    int k0;
    int k1;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R1: quiet out of reset with fast ticks present
    idle_check(30, "R1");
    // R1: high byte 0x00 with cleared low byte keeps it stopped
    wr_at(cyc, 2'd0, 8'h00);
    idle_check(40, "R1");

    // R2 R4 R9: period 5, tick every cycle
    phase = "R4";
    wr_at(cyc, 2'd1, 8'd5);
    k0 = cyc;
    wr_at(k0, 2'd0, 8'h00);
    predict(k0, k0 + 40, 5, NEVER, 5, "R2 R4 R9");
    stop_at(k0 + 40);
    idle_check(30, "R7");

    // R2: full 16-bit value 0x0102
    phase = "R2";
    wr_at(cyc, 2'd1, 8'h02);
    k0 = cyc;
    wr_at(k0, 2'd0, 8'h01);
    predict(k0, k0 + 600, 258, NEVER, 258, "R2");
    stop_at(k0 + 600);
    idle_check(20, "R7");

    // R5: fast tick only every third edge
    phase = "R5";
    fast_mode = 1'b1;
    wr_at(cyc, 2'd1, 8'd4);
    k0 = cyc;
    wr_at(k0, 2'd0, 8'h00);
    predict(k0, k0 + 60, 4, NEVER, 4, "R5");
    stop_at(k0 + 60);
    idle_check(20, "R5");

    // R6: line tick selected, fast pattern still toggling
    phase = "R6";
    wr_at(cyc, 2'd2, 8'h01);
    sel_b = 1'b1;
    wr_at(cyc, 2'd1, 8'd3);
    k0 = cyc;
    wr_at(k0, 2'd0, 8'h00);
    predict(k0, k0 + 200, 3, NEVER, 3, "R6");
    stop_at(k0 + 200);
    idle_check(20, "R6");
    wr_at(cyc, 2'd2, 8'h00);
    sel_b = 1'b0;
    fast_mode = 1'b0;

    // R3: low byte changed mid-run, applies at next reload only
    phase = "R3";
    wr_at(cyc, 2'd1, 8'd3);
    k0 = cyc;
    wr_at(k0, 2'd0, 8'h00);
    predict(k0, k0 + 50, 3, k0 + 10, 7, "R3");
    wr_at(k0 + 10, 2'd1, 8'd7);
    stop_at(k0 + 50);
    idle_check(20, "R3");

    // R8: high-byte write while running restarts the period
    phase = "R8";
    wr_at(cyc, 2'd1, 8'd10);
    k0 = cyc;
    wr_at(k0, 2'd0, 8'h00);
    k1 = k0 + 15;
    predict(k0, k1, 10, NEVER, 10, "R8");
    wr_at(k1, 2'd0, 8'h00);
    predict(k1, k1 + 40, 10, NEVER, 10, "R8");
    stop_at(k1 + 40);
    idle_check(20, "R8");

    // R7: zero picked up by automatic reload stops the timer
    phase = "R7";
    wr_at(cyc, 2'd1, 8'd4);
    k0 = cyc;
    wr_at(k0, 2'd0, 8'h00);
    predict(k0, k0 + 60, 4, k0 + 6, 0, "R7");
    wr_at(k0 + 6, 2'd1, 8'h00);
    while (cyc < k0 + 60) @(negedge clk);
    idle_check(30, "R7");

    repeat (5) @(negedge clk);
    while (expq.size() > 0) begin
      nchk++; nfail++;
      $display("FAIL %s: pulse never seen, actual none, expected after edge %0d",
               expq[0].tag, expq[0].ek);
      void'(expq.pop_front());
    end
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run hung, actual timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule